// File: doc/BRIEF.md
# Paravirtual Device I/O Register Block

This block is the register front end of a legacy paravirtual I/O device. A byte-addressed bus port carries an offset, an access size (byte, word or dword), write data and separate read and write strobes. Behind it sit the advertised and accepted feature words, a queue selector, one guest-physical ring address per queue with a fixed read-only size per queue, a device status byte and an interrupt status byte that clears when read. Offsets from 20 up to the end of a parameterised config window are forwarded unchanged to a device-specific pass-through port. Everything else reads as all ones.

The back end sees the accepted features, the status byte, every queue's ring address, a one-cycle notify pulse with the queue index the driver wrote, a level interrupt and a one-cycle device reset pulse. A small lifecycle state machine tracks the status byte. It has three states. ST_IDLE means status is zero. ST_ACTIVE means the driver has written a nonzero status. ST_RESET lasts one cycle and drives the reset pulse. Its transitions are as follows. From any state, a nonzero status write goes to ST_ACTIVE and a zero status write goes to ST_RESET. From ST_RESET, the next cycle with no status write goes to ST_IDLE.

Top module: `pvdev_regblk`

## Requirements
- R1: After reset, the accepted features, selector, every ring address, the status and the interrupt status are all zero, and irq, notify_valid, dev_reset and dev_live are low.
- R2: A dword read at offset 0 returns HOST_FEAT with bit NE_BIT (24) and bit BAD_BIT (30) forced to one. Writes to offset 0 have no effect.
- R3: A write at offset 4 stores the value as the accepted features. If bit 30 of the value is set, FALLBACK_FEAT is stored instead, or zero when HAS_FALLBACK is 0. A read at offset 4 returns the stored value.
- R4: A write at offset 8 stores the value shifted left by 12 as the ring address of the selected queue. A read at offset 8 returns that queue's address shifted right by 12.
- R5: A read at offset 12 returns the size of the selected queue from Q_SIZE, zero-extended. Writes there have no effect.
- R6: A write at offset 14 changes the selector only when the value is below NUM_Q. A read at offset 14 returns the selector.
- R7: A write at offset 16 raises notify_valid for exactly the cycle after the write edge, with notify_qidx equal to the low 16 bits written.
- R8: A write at offset 18 stores the low 8 bits as status and sets dev_live. A write of zero clears the features, the selector, all ring addresses and the interrupt status at that edge, and raises dev_reset for the one following cycle (ST_RESET).
- R9: A read at offset 19 returns the interrupt status and clears it at that edge. Bits on isr_set are ORed in, and they survive a clear in the same cycle.
- R10: irq follows bit 0 of the interrupt status.
- R11: A read of any offset that decodes to nothing returns all ones under the size mask. This covers offset 16, offsets between register bases, and offsets past the config window.
- R12: Offsets 20 to 20+CFG_LEN-1 drive cfg_rd/cfg_wr with cfg_off = offset-20, and a read there returns cfg_rdata.
- R13: Size code 0 is a byte, 1 a word, 2 or 3 a dword. Read data and write data are masked to the access size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational from the current state |
| isr_set | input | 8 | Interrupt status bits to set |
| irq | output | 1 | Level interrupt |
| notify_valid | output | 1 | Queue notify pulse |
| notify_qidx | output | 16 | Notified queue index |
| dev_reset | output | 1 | Device reset pulse |
| dev_live | output | 1 | Status is nonzero |
| guest_feat | output | 32 | Accepted features |
| dev_status | output | 8 | Status byte |
| q_addr | output | NUM_Q*(32+12) | Ring address of every queue |
| cfg_off | output | ADDR_W | Offset inside the config window |
| cfg_size | output | 2 | Access size to the window |
| cfg_wdata | output | 32 | Write data to the window |
| cfg_wr | output | 1 | Window write strobe |
| cfg_rd | output | 1 | Window read strobe |
| cfg_rdata | input | 32 | Window read data |

## Verification
The bench builds the block with four queues whose sizes are 8, 40, 96 and 0, an 8-byte config window, and a fallback feature mask of 3. With only four queues, every selector value can be written and every out-of-range value is close at hand. The small window puts both of its edges inside a full sweep of all 256 offsets. During that sweep, each read result, the window strobe and the window offset are computed arithmetically from a model of the written registers. This exposes decode holes, the all-ones default and the window bounds together.

// File: rtl/pvdev_pkg.sv
`timescale 1ns/1ps
package pvdev_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_RESET  = 2'd2
    } life_t;

    localparam int OFS_HOSTF  = 0;
    localparam int OFS_GUESTF = 4;
    localparam int OFS_PFN    = 8;
    localparam int OFS_QNUM   = 12;
    localparam int OFS_QSEL   = 14;
    localparam int OFS_NOTIFY = 16;
    localparam int OFS_STATUS = 18;
    localparam int OFS_ISR    = 19;
    localparam int OFS_CFG    = 20;
    localparam int PFN_SHIFT  = 12;

    function automatic logic [31:0] size_mask(input logic [1:0] sz);
        logic [31:0] m;
        unique case (sz)
            2'd0:    m = 32'h0000_00FF;
            2'd1:    m = 32'h0000_FFFF;
            default: m = 32'hFFFF_FFFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pvdev_lifecycle.sv
`timescale 1ns/1ps
module pvdev_lifecycle
    import pvdev_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stat_wr_i,
    input  logic stat_zero_i,
    output logic dev_reset_o,
    output logic dev_live_o
);
    life_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_ACTIVE: begin
                if (stat_wr_i) state_d = stat_zero_i ? ST_RESET : ST_ACTIVE;
            end
            ST_RESET: begin
                if (stat_wr_i) state_d = stat_zero_i ? ST_RESET : ST_ACTIVE;
                else           state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        dev_reset_o = (state_q == ST_RESET);
        dev_live_o  = (state_q == ST_ACTIVE);
    end

    p_pulse_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset_o |-> $past(stat_wr_i && stat_zero_i));
    p_live_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_live_o) |-> $past(stat_wr_i && !stat_zero_i));

endmodule

// File: rtl/pvdev_queue_bank.sv
`timescale 1ns/1ps
module pvdev_queue_bank
    import pvdev_pkg::*;
#(
    parameter int NUM_Q = 16,
    parameter logic [NUM_Q-1:0][15:0] Q_SIZE = {NUM_Q{16'd256}},
    localparam int PA_W   = 32 + PFN_SHIFT,
    localparam int QIDX_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
)(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear_i,
    input  logic                          sel_wr_i,
    input  logic [15:0]                   sel_val_i,
    input  logic                          pfn_wr_i,
    input  logic [31:0]                   pfn_val_i,
    output logic [15:0]                   sel_o,
    output logic [31:0]                   sel_pfn_o,
    output logic [15:0]                   sel_qsize_o,
    output logic [NUM_Q-1:0][PA_W-1:0]    qaddr_o
);
    logic [15:0]       sel_q;
    logic [QIDX_W-1:0] sel_idx;
    logic              sel_ok;

    assign sel_idx = sel_q[QIDX_W-1:0];
    assign sel_ok  = (32'(sel_val_i) < 32'(NUM_Q));

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)        sel_q <= '0;
        else if (sel_wr_i && sel_ok)  sel_q <= sel_val_i;
    end

    for (genvar q = 0; q < NUM_Q; q++) begin : g_ring
        always_ff @(posedge clk) begin
            if (!rst_n || clear_i)
                qaddr_o[q] <= '0;
            else if (pfn_wr_i && (32'(sel_idx) == q))
                qaddr_o[q] <= {pfn_val_i, {PFN_SHIFT{1'b0}}};
        end
    end

    always_comb begin
        sel_o       = sel_q;
        sel_pfn_o   = qaddr_o[sel_idx][PA_W-1:PFN_SHIFT];
        sel_qsize_o = Q_SIZE[sel_idx];
    end

    p_pfn_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pfn_wr_i && !clear_i) |=>
            qaddr_o[$past(sel_idx)] == {$past(pfn_val_i), {PFN_SHIFT{1'b0}}});
    p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr_i && (32'(sel_val_i) >= 32'(NUM_Q)) && !clear_i) |=> $stable(sel_q));

endmodule

// File: rtl/pvdev_isr.sv
`timescale 1ns/1ps
module pvdev_isr (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       rd_clr_i,
    input  logic [7:0] set_i,
    output logic [7:0] isr_o,
    output logic       irq_o
);
    logic [7:0] isr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= ((rd_clr_i || clear_i) ? 8'h00 : isr_q) | set_i;
    end

    always_comb begin
        isr_o = isr_q;
        irq_o = isr_q[0];
    end

    p_set_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != 8'h00) |=> ((isr_q & $past(set_i)) == $past(set_i)));
    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && set_i == 8'h00) |=> (isr_q == 8'h00));

endmodule

// File: rtl/pvdev_regblk.sv
`timescale 1ns/1ps
module pvdev_regblk
    import pvdev_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NUM_Q = 16,
    parameter logic [NUM_Q-1:0][15:0] Q_SIZE = {NUM_Q{16'd256}},
    parameter logic [31:0] HOST_FEAT = 32'h0000_0021,
    parameter int NE_BIT = 24,
    parameter int BAD_BIT = 30,
    parameter bit HAS_FALLBACK = 1'b1,
    parameter logic [31:0] FALLBACK_FEAT = 32'h0000_0001,
    parameter int CFG_LEN = 12,
    localparam int PA_W = 32 + PFN_SHIFT
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [1:0]                 bus_size,
    input  logic [31:0]                bus_wdata,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    output logic [31:0]                bus_rdata,
    input  logic [7:0]                 isr_set,
    output logic                       irq,
    output logic                       notify_valid,
    output logic [15:0]                notify_qidx,
    output logic                       dev_reset,
    output logic                       dev_live,
    output logic [31:0]                guest_feat,
    output logic [7:0]                 dev_status,
    output logic [NUM_Q-1:0][PA_W-1:0] q_addr,
    output logic [ADDR_W-1:0]          cfg_off,
    output logic [1:0]                 cfg_size,
    output logic [31:0]                cfg_wdata,
    output logic                       cfg_wr,
    output logic                       cfg_rd,
    input  logic [31:0]                cfg_rdata
);
    localparam logic [31:0] HOST_ADV =
        HOST_FEAT | (32'd1 << NE_BIT) | (32'd1 << BAD_BIT);
    localparam logic [31:0] FALLBACK_VAL = HAS_FALLBACK ? FALLBACK_FEAT : 32'h0;
    localparam int CFG_END = OFS_CFG + CFG_LEN;

    logic [31:0] amask, wval, raw;
    logic hit_hostf, hit_guest, hit_pfn, hit_qnum, hit_qsel;
    logic hit_notify, hit_status, hit_isr, in_cfg;
    logic dev_clr;
    logic [31:0] guest_q;
    logic [7:0]  status_q;
    logic        notify_q;
    logic [15:0] notify_idx_q;
    logic [15:0] sel_val, sel_qsize;
    logic [31:0] sel_pfn;
    logic [7:0]  isr_val;

    always_comb begin
        amask      = size_mask(bus_size);
        wval       = bus_wdata & amask;
        hit_hostf  = (32'(bus_addr) == OFS_HOSTF);
        hit_guest  = (32'(bus_addr) == OFS_GUESTF);
        hit_pfn    = (32'(bus_addr) == OFS_PFN);
        hit_qnum   = (32'(bus_addr) == OFS_QNUM);
        hit_qsel   = (32'(bus_addr) == OFS_QSEL);
        hit_notify = (32'(bus_addr) == OFS_NOTIFY);
        hit_status = (32'(bus_addr) == OFS_STATUS);
        hit_isr    = (32'(bus_addr) == OFS_ISR);
        in_cfg     = (32'(bus_addr) >= 32'(OFS_CFG)) && (32'(bus_addr) < 32'(CFG_END));
        dev_clr    = bus_wr && hit_status && (wval[7:0] == 8'h00);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || dev_clr)
            guest_q <= '0;
        else if (bus_wr && hit_guest)
            guest_q <= wval[BAD_BIT] ? FALLBACK_VAL : wval;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                    status_q <= '0;
        else if (bus_wr && hit_status) status_q <= wval[7:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            notify_q     <= 1'b0;
            notify_idx_q <= '0;
        end else begin
            notify_q <= bus_wr && hit_notify;
            if (bus_wr && hit_notify) notify_idx_q <= wval[15:0];
        end
    end

    pvdev_lifecycle u_life (
        .clk         (clk),
        .rst_n       (rst_n),
        .stat_wr_i   (bus_wr && hit_status),
        .stat_zero_i (wval[7:0] == 8'h00),
        .dev_reset_o (dev_reset),
        .dev_live_o  (dev_live)
    );

    pvdev_queue_bank #(.NUM_Q(NUM_Q), .Q_SIZE(Q_SIZE)) u_queues (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (dev_clr),
        .sel_wr_i    (bus_wr && hit_qsel),
        .sel_val_i   (wval[15:0]),
        .pfn_wr_i    (bus_wr && hit_pfn),
        .pfn_val_i   (wval),
        .sel_o       (sel_val),
        .sel_pfn_o   (sel_pfn),
        .sel_qsize_o (sel_qsize),
        .qaddr_o     (q_addr)
    );

    pvdev_isr u_isr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (dev_clr),
        .rd_clr_i (bus_rd && hit_isr),
        .set_i    (isr_set),
        .isr_o    (isr_val),
        .irq_o    (irq)
    );

    always_comb begin
        raw = 32'hFFFF_FFFF;
        if (hit_hostf)       raw = HOST_ADV;
        else if (hit_guest)  raw = guest_q;
        else if (hit_pfn)    raw = sel_pfn;
        else if (hit_qnum)   raw = {16'h0, sel_qsize};
        else if (hit_qsel)   raw = {16'h0, sel_val};
        else if (hit_status) raw = {24'h0, status_q};
        else if (hit_isr)    raw = {24'h0, isr_val};
        else if (in_cfg)     raw = cfg_rdata;
        bus_rdata = raw & amask;
    end

    always_comb begin
        cfg_off      = bus_addr - ADDR_W'(OFS_CFG);
        cfg_size     = bus_size;
        cfg_wdata    = bus_wdata;
        cfg_wr       = bus_wr && in_cfg;
        cfg_rd       = bus_rd && in_cfg;
        guest_feat   = guest_q;
        dev_status   = status_q;
        notify_valid = notify_q;
        notify_qidx  = notify_idx_q;
    end

    p_notify_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        notify_valid |-> $past(bus_wr && hit_notify));
    p_status_low_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_status) |=> (dev_status == $past(bus_wdata[7:0])));

endmodule

// File: tb/pvdev_regblk_tb.sv
`timescale 1ns/1ps
module pvdev_regblk_tb;
    localparam int NQ = 4;
    localparam logic [NQ-1:0][15:0] SIZES = {16'd0, 16'd96, 16'd40, 16'd8};
    localparam logic [31:0] HOSTF = 32'h0000_00A5;
    localparam logic [31:0] FBACK = 32'h0000_0003;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [1:0] bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [7:0] isr_set = '0;
    logic irq, notify_valid, dev_reset, dev_live;
    logic [15:0] notify_qidx;
    logic [31:0] guest_feat;
    logic [7:0] dev_status;
    logic [NQ-1:0][43:0] q_addr;
    logic [7:0] cfg_off;
    logic [1:0] cfg_size;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic cfg_wr, cfg_rd;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;
    logic s_cfg_rd, s_cfg_wr;
    logic [7:0] s_cfg_off;
    logic [31:0] s_cfg_wdata;

    always #5 clk = ~clk;
    assign cfg_rdata = 32'hC0DE_0000 | {24'h0, cfg_off};

    pvdev_regblk #(.ADDR_W(8), .NUM_Q(NQ), .Q_SIZE(SIZES), .HOST_FEAT(HOSTF),
                   .HAS_FALLBACK(1'b1), .FALLBACK_FEAT(FBACK), .CFG_LEN(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .isr_set(isr_set), .irq(irq), .notify_valid(notify_valid), .notify_qidx(notify_qidx),
        .dev_reset(dev_reset), .dev_live(dev_live), .guest_feat(guest_feat),
        .dev_status(dev_status), .q_addr(q_addr), .cfg_off(cfg_off), .cfg_size(cfg_size),
        .cfg_wdata(cfg_wdata), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
        #1;
        s_cfg_wr = cfg_wr; s_cfg_off = cfg_off; s_cfg_wdata = cfg_wdata;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] sz, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_rd = 1'b1;
        #1;
        d = bus_rdata; s_cfg_rd = cfg_rd; s_cfg_off = cfg_off;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic set_isr(input logic [7:0] v);
        @(negedge clk);
        isr_set = v;
        @(posedge clk); #1;
        isr_set = 8'h00;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, expv, pfn;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", 64'(irq), 0);
        chk("R1 notify", 64'(notify_valid), 0);
        chk("R1 dev_reset", 64'(dev_reset), 0);
        chk("R1 dev_live", 64'(dev_live), 0);
        chk("R1 guest_feat", 64'(guest_feat), 0);
        chk("R1 q_addr", 64'(|q_addr), 0);
        rd(8'd14, 2'd2, d); chk("R1 selector", 64'(d), 0);
        rd(8'd18, 2'd2, d); chk("R1 status", 64'(d), 0);
        rd(8'd19, 2'd2, d); chk("R1 isr", 64'(d), 0);

        // R2 advertised features, read-only
        expv = HOSTF | (32'd1 << 24) | (32'd1 << 30);
        rd(8'd0, 2'd2, d); chk("R2 host features", 64'(d), 64'(expv));
        wr(8'd0, 2'd2, 32'hFFFF_FFFF);
        rd(8'd0, 2'd2, d); chk("R2 host write ignored", 64'(d), 64'(expv));

        // R3 accepted features and fallback
        wr(8'd4, 2'd2, 32'h1234_5678);
        rd(8'd4, 2'd2, d); chk("R3 guest readback", 64'(d), 64'h1234_5678);
        chk("R3 guest port", 64'(guest_feat), 64'h1234_5678);
        wr(8'd4, 2'd2, 32'h4000_0001);
        rd(8'd4, 2'd2, d); chk("R3 fallback", 64'(d), 64'(FBACK));

        // R13 size masking
        rd(8'd0, 2'd0, d); chk("R13 byte read", 64'(d), 64'hA5);
        wr(8'd4, 2'd0, 32'hDEAD_BEEF);
        rd(8'd4, 2'd2, d); chk("R13 byte write", 64'(d), 64'hEF);
        wr(8'd4, 2'd1, 32'h0BAD_CAFE);
        rd(8'd4, 2'd3, d); chk("R13 word write", 64'(d), 64'hCAFE);
        rd(8'd0, 2'd1, d); chk("R13 word read", 64'(d), 64'h00A5);

        // R4 R5 R6 queue sweep
        for (int q = 0; q < NQ; q++) begin
            pfn = 32'h1357_0000 + 32'(q) * 32'h0001_1111;
            wr(8'd14, 2'd1, 32'(q));
            rd(8'd14, 2'd1, d); chk("R6 selector accepted", 64'(d), 64'(q));
            wr(8'd8, 2'd2, pfn);
            chk("R4 stored address", 64'(q_addr[q]), {20'h0, pfn, 12'h000});
            rd(8'd8, 2'd2, d); chk("R4 pfn readback", 64'(d), 64'(pfn));
            rd(8'd12, 2'd1, d); chk("R5 queue size", 64'(d), 64'(SIZES[q]));
            wr(8'd12, 2'd1, 32'h7777);
            rd(8'd12, 2'd1, d); chk("R5 size write ignored", 64'(d), 64'(SIZES[q]));
        end
        for (int q = 0; q < NQ; q++) begin
            wr(8'd14, 2'd1, 32'(q));
            rd(8'd8, 2'd2, d);
            chk("R4 per-queue independence", 64'(d), 64'(32'h1357_0000 + 32'(q) * 32'h0001_1111));
        end
        wr(8'd14, 2'd1, 32'd1);
        wr(8'd14, 2'd1, 32'd4);
        rd(8'd14, 2'd1, d); chk("R6 sel=NUM_Q rejected", 64'(d), 1);
        wr(8'd14, 2'd1, 32'hFFFF);
        rd(8'd14, 2'd1, d); chk("R6 sel=FFFF rejected", 64'(d), 1);

        // R7 notify pulse
        wr(8'd16, 2'd1, 32'd2);
        chk("R7 notify high", 64'(notify_valid), 1);
        chk("R7 notify index", 64'(notify_qidx), 2);
        @(posedge clk); #1;
        chk("R7 notify one cycle", 64'(notify_valid), 0);
        wr(8'd16, 2'd2, 32'h0003_1234);
        chk("R7 notify index masked", 64'(notify_qidx), 64'h1234);

        // R9 R10 interrupt status
        set_isr(8'h05);
        chk("R10 irq set", 64'(irq), 1);
        rd(8'd19, 2'd0, d); chk("R9 isr read", 64'(d), 5);
        chk("R10 irq after clear", 64'(irq), 0);
        rd(8'd19, 2'd0, d); chk("R9 isr cleared", 64'(d), 0);
        set_isr(8'h02);
        chk("R10 irq bit1 only", 64'(irq), 0);
        @(negedge clk);
        isr_set = 8'h01; bus_addr = 8'd19; bus_size = 2'd0; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        isr_set = 8'h00; bus_rd = 1'b0;
        chk("R9 read during set", 64'(d), 2);
        chk("R9 set wins over clear", 64'(irq), 1);
        rd(8'd19, 2'd0, d); chk("R9 only set bit kept", 64'(d), 1);

        // R12 config window write
        wr(8'd23, 2'd2, 32'hA1B2_C3D4);
        chk("R12 cfg_wr", 64'(s_cfg_wr), 1);
        chk("R12 cfg_off", 64'(s_cfg_off), 3);
        chk("R12 cfg_wdata", 64'(s_cfg_wdata), 64'hA1B2_C3D4);
        wr(8'd28, 2'd2, 32'h1);
        chk("R12 cfg_wr past window", 64'(s_cfg_wr), 0);

        // R11 R12 full offset sweep with known state
        wr(8'd4, 2'd2, 32'h0BAD_F00D);
        wr(8'd14, 2'd1, 32'd1);
        wr(8'd8, 2'd2, 32'h000A_BCDE);
        wr(8'd18, 2'd0, 32'h07);
        for (int a = 0; a < 256; a++) begin
            unique case (a)
                0:  expv = HOSTF | (32'd1 << 24) | (32'd1 << 30);
                4:  expv = 32'h0BAD_F00D;
                8:  expv = 32'h000A_BCDE;
                12: expv = 32'd40;
                14: expv = 32'd1;
                18: expv = 32'h07;
                19: expv = 32'h0;
                default: expv = (a >= 20 && a < 28) ? (32'hC0DE_0000 | 32'(a - 20)) : 32'hFFFF_FFFF;
            endcase
            rd(8'(a), 2'd2, d);
            chk((a >= 20 && a < 28) ? "R12 window read" : "R11 offset sweep", 64'(d), 64'(expv));
            chk("R12 cfg_rd strobe", 64'(s_cfg_rd), 64'(a >= 20 && a < 28));
            if (a >= 20 && a < 28) chk("R12 cfg_off", 64'(s_cfg_off), 64'(a - 20));
        end
        rd(8'd200, 2'd0, d); chk("R11 byte unmapped", 64'(d), 64'hFF);

        // R8 status and device reset
        wr(8'd18, 2'd1, 32'h01FF);
        rd(8'd18, 2'd2, d); chk("R8 status low byte", 64'(d), 64'hFF);
        chk("R8 dev_live", 64'(dev_live), 1);
        wr(8'd14, 2'd1, 32'd2);
        wr(8'd8, 2'd2, 32'h55);
        set_isr(8'h04);
        wr(8'd18, 2'd0, 32'h00);
        chk("R8 reset pulse", 64'(dev_reset), 1);
        chk("R8 not live", 64'(dev_live), 0);
        @(posedge clk); #1;
        chk("R8 reset one cycle", 64'(dev_reset), 0);
        chk("R8 addresses cleared", 64'(|q_addr), 0);
        chk("R8 features cleared", 64'(guest_feat), 0);
        rd(8'd14, 2'd1, d); chk("R8 selector cleared", 64'(d), 0);
        rd(8'd19, 2'd0, d); chk("R8 isr cleared", 64'(d), 0);
        rd(8'd18, 2'd0, d); chk("R8 status zero", 64'(d), 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule